// File: doc/BRIEF.md
# SAR Conversion Timing and Averaging Sequencer

This block paces every conversion of a successive-approximation ADC. It derives a converter tick from the input clock by a selectable power-of-two divisor. It then walks a fixed startup window, followed by one sample window and one base conversion window for each sample. Each sample taken from the analog front end is added into an accumulator. When the last sample has been converted, the block presents the averaged value together with a single-cycle done strobe.

Every conversion runs for exactly `D × (6 + N × (25 + L))` input clocks. `D` is the clock divisor, `N` is the averaging count and `L` is the sample-window length. All three come from small encoded configuration fields. The block latches the fields when a conversion starts. In continuous mode a new conversion begins as soon as the previous one ends. A stop request abandons the conversion in progress.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While and after reset, `busy_o`, `done_o` and `result_o` are all zero.
- R2: When `start_i` is accepted at clock edge s, `done_o` is high only in the cycle that follows edge s + D×(6 + N×(25 + L)), and it is low at every earlier edge.
- R3: N is 1 when `avg_en_i` is 0, whatever the value of `avg_sel_i`. When `avg_en_i` is 1, `avg_sel_i` codes 00, 01, 10 and 11 give N = 4, 8, 16 and 32.
- R4: With `lst_long_i` = 0, `lst_sel_i` codes 00 to 11 give L = 3, 5, 7 and 9 converter ticks. With `lst_long_i` = 1, the same codes give L = 13, 17, 21 and 25.
- R5: `div_sel_i` codes 00 to 11 divide the input clock by 1, 2, 4 and 8. `clk_src_i` = 01 doubles that divisor, so 01 combined with code 11 divides by 16. Any other `clk_src_i` value leaves the divisor unchanged.
- R6: Sample j (counting from 0) is taken from `sample_i` at edge s + D×(6 + j×(25 + L) + L). `result_o` is the sum of the N samples shifted right by log2 N.
- R7: A start request while busy has no effect. Configuration changes made during a conversion do not alter its timing or its averaging.
- R8: `stop_i` during a conversion clears `busy_o` at the next edge, and that conversion produces no done pulse.
- R9: With `cont_i` high at the end of a conversion, the next conversion begins at that same edge and its timing is measured from that edge.
- R10: `done_o` lasts exactly one cycle. `result_o` changes only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion (used only when idle) |
| stop_i | input | 1 | Abort the conversion in progress |
| cont_i | input | 1 | Restart at once after each completed conversion |
| avg_en_i | input | 1 | Enable hardware averaging |
| avg_sel_i | input | 2 | Averaging count code |
| lst_long_i | input | 1 | Choose the long sample-window set |
| lst_sel_i | input | 2 | Sample-window length code |
| div_sel_i | input | 2 | Converter clock divisor code |
| clk_src_i | input | 2 | Clock source code; 01 halves the input clock |
| sample_i | input | DW | Digital sample value from the front end |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | DW | Averaged result |

## Verification
The assertions treat start, stop and the configuration fields as arbitrary inputs sampled once per clock. The properties about the latched configuration and the sample counter depend only on internal state that the block itself latches. The done-pulse and no-done-when-idle properties assume the shortest conversion is far longer than one cycle, which always holds because the startup window alone is six ticks. The stimulus changes every input at the falling edge, drives `sample_i` from a known function of the edge count so that each capture edge can be identified, and keeps `cont_i` stable around each completion edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int LST_W  = 5;
  localparam int NLOG_W = 3;
  localparam int DLOG_W = 3;

  typedef struct packed {
    logic [LST_W-1:0]  lst;
    logic [NLOG_W-1:0] nlog;
    logic [DLOG_W-1:0] dlog;
  } seq_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_SAMP  = 2'd2,
    PH_CONV  = 2'd3
  } phase_t;
endpackage

// File: rtl/adc_seq_cfg_decode.sv
module adc_seq_cfg_decode
  import adc_seq_pkg::*;
#(
  parameter bit ALLOW_HALF = 1'b1
) (
  input  logic       avg_en_i,
  input  logic [1:0] avg_sel_i,
  input  logic       lst_long_i,
  input  logic [1:0] lst_sel_i,
  input  logic [1:0] div_sel_i,
  input  logic [1:0] clk_src_i,
  output seq_cfg_t   cfg_o
);
  logic [LST_W-1:0] lst_short, lst_long;

  // Sample window: short set steps by 2 from 3, long set steps by 4 from 13
  assign lst_short = LST_W'(3) + {2'b00, lst_sel_i, 1'b0};
  assign lst_long  = LST_W'(13) + {1'b0, lst_sel_i, 2'b00};

  always_comb begin
    cfg_o.lst  = lst_long_i ? lst_long : lst_short;
    cfg_o.nlog = avg_en_i ? NLOG_W'({1'b0, avg_sel_i} + 3'd2) : '0;
  end

  generate
    if (ALLOW_HALF) begin : g_half
      assign cfg_o.dlog = DLOG_W'({1'b0, div_sel_i}) + DLOG_W'(clk_src_i == 2'b01);
    end else begin : g_nohalf
      assign cfg_o.dlog = DLOG_W'({1'b0, div_sel_i});
    end
  endgenerate
endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [DLOG_W-1:0] dlog_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim    = CNT_W'((32'd1 << dlog_i) - 32'd1);
  assign tick_o = run_i && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (tick_o)   cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R5: with a divisor above one, ticks never fall on neighbouring cycles
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_o && lim != '0) |=> !tick_o);
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int DW        = 12,
  parameter int START_CYC = 6,
  parameter int BASE_CYC  = 25,
  parameter int MAX_NLOG  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cont_i,
  input  seq_cfg_t      cfg_in,
  input  logic [DW-1:0] sample_i,
  input  logic          tick_i,
  output seq_cfg_t      cfg_q,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  localparam int MAXW  = (BASE_CYC > 32) ? BASE_CYC : 32;
  localparam int PH_W  = $clog2(MAXW + 1);
  localparam int SMP_W = MAX_NLOG + 1;
  localparam int ACC_W = DW + MAX_NLOG;

  phase_t           phase;
  logic [PH_W-1:0]  ph_cnt;
  logic [SMP_W-1:0] smp_cnt;
  logic [SMP_W-1:0] last_smp;
  logic [ACC_W-1:0] acc;

  assign busy_o   = (phase != PH_IDLE);
  assign last_smp = SMP_W'((32'd1 << cfg_q.nlog) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      ph_cnt   <= '0;
      smp_cnt  <= '0;
      acc      <= '0;
      cfg_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_i && !stop_i) begin
          phase   <= PH_START;
          ph_cnt  <= PH_W'(START_CYC - 1);
          smp_cnt <= '0;
          acc     <= '0;
          cfg_q   <= cfg_in;
        end
      end else if (stop_i) begin
        phase <= PH_IDLE;
      end else if (tick_i) begin
        if (ph_cnt != '0) begin
          ph_cnt <= ph_cnt - 1'b1;
        end else begin
          case (phase)
            PH_START: begin
              phase  <= PH_SAMP;
              ph_cnt <= PH_W'(cfg_q.lst - 5'd1);
            end
            PH_SAMP: begin
              acc    <= acc + ACC_W'(sample_i);
              phase  <= PH_CONV;
              ph_cnt <= PH_W'(BASE_CYC - 1);
            end
            PH_CONV: begin
              if (smp_cnt == last_smp) begin
                result_o <= DW'(acc >> cfg_q.nlog);
                done_o   <= 1'b1;
                if (cont_i) begin
                  phase   <= PH_START;
                  ph_cnt  <= PH_W'(START_CYC - 1);
                  smp_cnt <= '0;
                  acc     <= '0;
                  cfg_q   <= cfg_in;
                end else begin
                  phase <= PH_IDLE;
                end
              end else begin
                smp_cnt <= smp_cnt + 1'b1;
                phase   <= PH_SAMP;
                ph_cnt  <= PH_W'(cfg_q.lst - 5'd1);
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R10: completion strobe is a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: result only moves together with the strobe
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
  // R8: stop abandons the conversion without a strobe
  p_stop_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && stop_i) |=> (!busy_o && !done_o));
  // R7: latched configuration cannot change mid-conversion
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick_i) |=> $stable(cfg_q));
  // R2: no strobe can follow an idle cycle
  p_idle_no_done_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !done_o);
  // R3: sample index never passes the configured count
  p_smp_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (smp_cnt <= last_smp));
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DW         = 12,
  parameter int START_CYC  = 6,
  parameter int BASE_CYC   = 25,
  parameter int MAX_NLOG   = 5,
  parameter bit ALLOW_HALF = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cont_i,
  input  logic          avg_en_i,
  input  logic [1:0]    avg_sel_i,
  input  logic          lst_long_i,
  input  logic [1:0]    lst_sel_i,
  input  logic [1:0]    div_sel_i,
  input  logic [1:0]    clk_src_i,
  input  logic [DW-1:0] sample_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  localparam int DIV_CNT_W = 4 + (ALLOW_HALF ? 1 : 0);

  seq_cfg_t cfg_dec;
  seq_cfg_t cfg_q;
  logic     tick;

  adc_seq_cfg_decode #(.ALLOW_HALF(ALLOW_HALF)) u_dec (
    .avg_en_i  (avg_en_i),
    .avg_sel_i (avg_sel_i),
    .lst_long_i(lst_long_i),
    .lst_sel_i (lst_sel_i),
    .div_sel_i (div_sel_i),
    .clk_src_i (clk_src_i),
    .cfg_o     (cfg_dec)
  );

  adc_seq_clkdiv #(.CNT_W(DIV_CNT_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .run_i (busy_o),
    .dlog_i(cfg_q.dlog),
    .tick_o(tick)
  );

  adc_seq_core #(
    .DW       (DW),
    .START_CYC(START_CYC),
    .BASE_CYC (BASE_CYC),
    .MAX_NLOG (MAX_NLOG)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .cont_i  (cont_i),
    .cfg_in  (cfg_dec),
    .sample_i(sample_i),
    .tick_i  (tick),
    .cfg_q   (cfg_q),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o)
  );
endmodule

// File: tb/tb_adc_conv_sequencer.sv
`timescale 1ns/1ps
module tb_adc_conv_sequencer;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 0, stop_i = 0, cont_i = 0;
  logic          avg_en_i = 0, lst_long_i = 0;
  logic [1:0]    avg_sel_i = 0, lst_sel_i = 0, div_sel_i = 0, clk_src_i = 0;
  logic [DW-1:0] sample_i = 0;
  logic          busy_o, done_o;
  logic [DW-1:0] result_o;

  int  edge_cnt = 0;
  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  adc_conv_sequencer dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .cont_i(cont_i),
    .avg_en_i(avg_en_i), .avg_sel_i(avg_sel_i), .lst_long_i(lst_long_i),
    .lst_sel_i(lst_sel_i), .div_sel_i(div_sel_i), .clk_src_i(clk_src_i),
    .sample_i(sample_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  function automatic logic [DW-1:0] fval(int e);
    return DW'((e * 773 + 91) % 4096);
  endfunction

  initial forever begin @(posedge clk); edge_cnt++; end
  initial forever begin @(negedge clk); sample_i = fval(edge_cnt); end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(bit ae, int as, bit ll, int ls, int ds, int cs);
    avg_en_i = ae; avg_sel_i = 2'(as); lst_long_i = ll;
    lst_sel_i = 2'(ls); div_sel_i = 2'(ds); clk_src_i = 2'(cs);
  endtask

  // Timing parameters computed from R3, R4, R5
  task automatic model(bit ae, int as, bit ll, int ls, int ds, int cs,
                       output int n, output int l, output int d);
    n = ae ? (4 << as) : 1;
    l = ll ? (13 + 4 * ls) : (3 + 2 * ls);
    d = (1 << ds) * ((cs == 1) ? 2 : 1);
  endtask

  function automatic int expect_avg(int s, int n, int l, int d);
    int sum = 0;
    int sh = 0;
    for (int j = 0; j < n; j++) sum += fval(s + d * (6 + j * (25 + l) + l) - 1);
    while ((1 << sh) < n) sh++;
    return sum >> sh;
  endfunction

  // R2..R6, R9: nconv back-to-back conversions, checking timing and result
  task automatic t_conv(bit ae, int as, bit ll, int ls, int ds, int cs,
                        int nconv, string tag);
    int n, l, d, t, s, target;
    bit early;
    model(ae, as, ll, ls, ds, cs, n, l, d);
    t = d * (6 + n * (25 + l));
    @(negedge clk);
    set_cfg(ae, as, ll, ls, ds, cs);
    cont_i = (nconv > 1);
    start_i = 1; s = edge_cnt + 1;
    @(negedge clk); start_i = 0;
    for (int c = 0; c < nconv; c++) begin
      target = s + (c + 1) * t;
      early = 0;
      while (edge_cnt < target) begin
        if (done_o) early = 1;
        @(negedge clk);
      end
      check(!early, {"R2 no early done ", tag}, early, 0);
      check(done_o == 1'b1, {"R2 done at expected edge ", tag}, done_o, 1);
      check(result_o == DW'(expect_avg(s + c * t, n, l, d)), {"R6 result ", tag},
            result_o, expect_avg(s + c * t, n, l, d));
      if (c == nconv - 2) cont_i = 0;
      if (c == nconv - 1) check(!busy_o, {"R9 idle after last ", tag}, busy_o, 0);
      else check(busy_o, {"R9 busy on restart ", tag}, busy_o, 1);
      @(negedge clk);
      check(!done_o, {"R10 done one cycle ", tag}, done_o, 1'b0);
    end
  endtask

  task automatic t_busy_start();
    int s; bit extra = 0;
    logic [DW-1:0] r;
    @(negedge clk);
    set_cfg(0, 0, 0, 0, 0, 0);
    start_i = 1; s = edge_cnt + 1;
    @(negedge clk); start_i = 0;
    while (edge_cnt < s + 9) @(negedge clk);
    start_i = 1; set_cfg(1, 3, 1, 3, 3, 1);
    @(negedge clk); start_i = 0;
    while (edge_cnt < s + 34) @(negedge clk);
    check(done_o == 1'b1, "R7 done at latched timing", done_o, 1);
    check(result_o == fval(s + 8), "R7 latched single sample", result_o, fval(s + 8));
    r = result_o;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done_o || busy_o) extra = 1;
    end
    check(!extra, "R7 second start ignored", extra, 0);
    check(result_o == r, "R10 result held", result_o, r);
  endtask

  task automatic t_stop();
    int s; bit got = 0;
    logic [DW-1:0] r;
    r = result_o;
    @(negedge clk);
    set_cfg(0, 0, 0, 0, 0, 0);
    start_i = 1; s = edge_cnt + 1;
    @(negedge clk); start_i = 0;
    while (edge_cnt < s + 19) @(negedge clk);
    check(busy_o, "R8 busy before stop", busy_o, 1);
    stop_i = 1;
    @(negedge clk); stop_i = 0;
    check(!busy_o, "R8 busy cleared by stop", busy_o, 0);
    for (int k = 0; k < 60; k++) begin
      if (done_o) got = 1;
      @(negedge clk);
    end
    check(!got, "R8 no done after stop", got, 0);
    check(result_o == r, "R8 result untouched", result_o, r);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!busy_o && !done_o, "R1 flags clear in reset", {busy_o, done_o}, 0);
    check(result_o == '0, "R1 result zero in reset", result_o, 0);
    rst = 0;
    @(negedge clk);
    check(!busy_o && !done_o && result_o == '0, "R1 idle after reset", busy_o, 0);
    t_conv(0, 0, 0, 0, 0, 0, 1, "R2 base N1 L3 D1");
    t_conv(1, 0, 0, 1, 1, 0, 1, "R3 N4 L5 D2");
    t_conv(1, 1, 1, 0, 2, 0, 1, "R4 N8 L13 D4");
    t_conv(0, 3, 1, 3, 3, 1, 1, "R5 avg off N1 L25 D16");
    t_conv(1, 3, 0, 3, 0, 2, 1, "R3 N32 L9 D1");
    t_conv(1, 2, 1, 2, 3, 0, 1, "R4 N16 L21 D8");
    t_conv(1, 0, 0, 2, 0, 1, 1, "R5 halved D2 L7");
    t_busy_start();
    t_stop();
    t_conv(1, 0, 1, 1, 1, 0, 3, "R9 continuous N4 L17 D2");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule